// File: doc/BRIEF.md
# Iterative Carry-Less Multiplier

This block multiplies two 32-bit operands as polynomials over GF(2): partial products are combined with XOR, so no carry ever moves between bit positions. The full product is 64 bits wide. The caller picks one of three 32-bit views of it: the lower word, the upper word, or the reversed view. The reversed view is the carry-less product of the two bit-reversed operands. Its low word is then bit-reversed again.

A request is made by pulsing `start` while the unit is idle, with both operands and the view code on the inputs. The unit walks the second operand one bit per clock. For each set bit it XORs a correspondingly shifted copy of the first operand into a 64-bit accumulator. After exactly 32 steps it raises `done` for one cycle. The selected view then stays on `result` until the next accepted request.

Top module: `clmul_iter`

## Requirements
- R1: View code 2'b01 returns bits 31:0 of the carry-less product, defined as the XOR over i = 0..31 of (op_a << i) for every i where op_b[i] is 1.
- R2: View code 2'b11 returns bits 63:32 of that carry-less product.
- R3: View code 2'b10 returns the bit reversal of the low 32 bits of the carry-less product of bit-reversed op_a and bit-reversed op_b.
- R4: View code 2'b00 behaves as the low view (2'b01).
- R5: A start accepted while idle raises busy at the next clock edge, and busy stays high for exactly 32 cycles.
- R6: done is high for exactly one cycle, and that cycle is the first cycle in which busy is low again. The result is valid from that cycle on.
- R7: After done, result holds its value until the next accepted start.
- R8: start asserted while busy is ignored: the operands, the view code and the step count of the running request are kept, and the result is the one for the first request.
- R9: While rst_n is low at a clock edge (synchronous, active low), the unit clears busy, done, the step counter and the accumulator, so result reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request; taken only while busy is low |
| op_a | input | 32 | Multiplicand, shifted and XOR-accumulated |
| op_b | input | 32 | Multiplier, scanned one bit per clock from bit 0 |
| view | input | 2 | Result view: 00/01 low, 11 high, 10 reversed |
| busy | output | 1 | High while the 32 steps run |
| done | output | 1 | One-cycle pulse when the result becomes valid |
| result | output | 32 | Selected 32-bit view of the product |

## Verification
The vectors cover zero and all-ones operands and single bits at positions 0 and 31. Bit 31 times bit 31 lands on product bit 62, which is the bit an off-by-one reversed view or a dropped top step would lose. All-ones operands show whether XOR cancellation works: a design that adds with carries would report a dense high word instead of the alternating pattern. A second start is injected mid-run; a design that reloads on it would end late or return the second product. A reset in mid-run shows whether the accumulator is really cleared, since stale partial products would show up in result.

// File: rtl/clmul_seq_pkg.sv
// Package: shared view encoding for the iterative carry-less multiplier.
// Assumes the two low bits of the view code follow the neighbour decoder's
// function field (01 low, 11 high, 10 reversed); 00 is folded onto low.
package clmul_seq_pkg;
    typedef enum logic [1:0] {
        VIEW_LOW_ALT = 2'b00,
        VIEW_LOW     = 2'b01,
        VIEW_REV     = 2'b10,
        VIEW_HIGH    = 2'b11
    } view_e;
endpackage

// File: rtl/clmul_acc_engine.sv
// Module: shift-and-XOR accumulation engine.
// Loads operands on an accepted start and then runs W steps, one bit of the
// multiplier per clock, LSB first. Assumes start is ignored while busy.
module clmul_acc_engine #(
    parameter int unsigned W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    output logic             busy,
    output logic             done,
    output logic [2*W-1:0]   acc
);
    localparam int unsigned CW   = $clog2(W);
    localparam int unsigned PW   = 2 * W;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [PW-1:0] a_sh;
    logic [W-1:0]  b_sh;
    logic [CW-1:0] step;

    // Purpose: load on accepted start, then accumulate one partial product per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            a_sh <= '0;
            b_sh <= '0;
            step <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                acc  <= '0;
                a_sh <= {{W{1'b0}}, op_a};
                b_sh <= op_b;
                step <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                if (b_sh[0]) begin
                    acc <= acc ^ a_sh;
                end
                a_sh <= a_sh << 1;
                b_sh <= b_sh >> 1;
                step <= step + CW'(1);
                if (step == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step != LAST) |=> busy);

    assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step == LAST) |=> (!busy && done));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && step != LAST) |=> (step == CW'($past(step) + CW'(1))));
endmodule

// File: rtl/clmul_view_sel.sv
// Module: picks the 32-bit view from the 2W-bit product.
// The reversed view equals product bits [2W-2:W-1], so no reversal network
// is needed. Assumes acc holds the finished product when read.
module clmul_view_sel #(
    parameter int unsigned W = 32
) (
    input  clmul_seq_pkg::view_e view,
    input  logic [2*W-1:0]       acc,
    output logic [W-1:0]         res
);
    import clmul_seq_pkg::*;

    // Purpose: window selection over the accumulator.
    always_comb begin
        case (view)
            VIEW_HIGH: res = acc[2*W-1:W];
            VIEW_REV:  res = acc[2*W-2:W-1];
            default:   res = acc[W-1:0];
        endcase
    end
endmodule

// File: rtl/clmul_iter.sv
// Module: top of the iterative carry-less multiplier.
// Latches the view code with the operands on an accepted start; the result
// is a view of the engine's accumulator and is stable while idle.
module clmul_iter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   view,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    import clmul_seq_pkg::*;

    view_e           view_q;
    logic [2*W-1:0]  acc;

    // Purpose: capture the requested view only when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            view_q <= VIEW_LOW_ALT;
        end else if (start && !busy) begin
            view_q <= view_e'(view);
        end
    end

    clmul_acc_engine #(.W(W)) engine_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .op_a  (op_a),
        .op_b  (op_b),
        .busy  (busy),
        .done  (done),
        .acc   (acc)
    );

    clmul_view_sel #(.W(W)) sel_i (
        .view (view_q),
        .acc  (acc),
        .res  (result)
    );

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_view_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(view_q) || !busy);
endmodule

// File: tb/clmul_iter_tb_top.sv
module clmul_iter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [1:0]  view = 2'b00;
    logic        busy, done;
    logic [31:0] result;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    clmul_iter dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .view(view), .busy(busy), .done(done), .result(result)
    );

    localparam int NV = 11;
    localparam logic [31:0] VA [NV] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0000, 32'h0000_0001, 32'h0000_0001,
        32'h1234_5678, 32'hDEAD_BEEF, 32'hA5A5_A5A5};
    localparam logic [31:0] VB [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0000, 32'h0000_0001, 32'h8000_0000,
        32'h9ABC_DEF0, 32'h0F0F_0F0F, 32'h5A5A_5A5A};
    localparam logic [1:0] VM [NV] = '{2'b01, 2'b01, 2'b11, 2'b10, 2'b11, 2'b10,
        2'b01, 2'b11, 2'b10, 2'b00, 2'b11};

    function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p = '0;
        for (int i = 0; i < 32; i++) if (b[i]) p = p ^ ({32'h0, a} << i);
        return p;
    endfunction

    function automatic logic [31:0] rev32(input logic [31:0] x);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = x[31-i];
        return r;
    endfunction

    function automatic logic [31:0] ref_view(input logic [31:0] a, input logic [31:0] b,
                                             input logic [1:0] m);
        logic [63:0] p;
        if (m == 2'b10) begin
            p = ref_prod(rev32(a), rev32(b));
            return rev32(p[31:0]);
        end
        p = ref_prod(a, b);
        return (m == 2'b11) ? p[63:32] : p[31:0];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Issue a request; optionally inject a second start mid-run (R8).
    task automatic run_one(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                           input bit inject, input string req);
        int n;
        logic [31:0] held;
        @(negedge clk);
        op_a = a; op_b = b; view = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R5 busy after start", busy, 1);
        n = 1;
        while (busy && n < 100) begin
            if (inject && n == 5) begin
                op_a = ~a; op_b = ~b; view = ~m; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (busy) n++;
        end
        start = 1'b0;
        chk("R5 busy length", n, 32);
        chk("R6 done with busy low", done, 1);
        chk(req, result, ref_view(a, b, m));
        held = result;
        @(negedge clk);
        chk("R6 done one cycle", done, 0);
        repeat (3) @(negedge clk);
        chk("R7 result held", result, held);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset busy", busy, 0);
        chk("R9 reset done", done, 0);
        chk("R9 reset result", result, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            string tag;
            case (VM[v])
                2'b01:   tag = "R1 low view";
                2'b11:   tag = "R2 high view";
                2'b10:   tag = "R3 reversed view";
                default: tag = "R4 view 00 as low";
            endcase
            run_one(VA[v], VB[v], VM[v], 1'b0, tag);
        end

        // R8: start while busy is ignored
        run_one(32'hCAFE_F00D, 32'h1357_9BDF, 2'b11, 1'b1, "R8 ignored restart");

        // R9: reset in mid-run clears state
        @(negedge clk);
        op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF; view = 2'b01; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mid-run reset busy", busy, 0);
        chk("R9 mid-run reset result", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 stays idle after reset", busy, 0);

        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end
endmodule